// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Array

This block is the output stage of a small programmable logic device. An AND-array outside the block supplies a group of product terms to each of eight macrocells. Each macrocell ORs its terms into a sum and can invert that sum. It then either drives the result straight to its I/O pin or stores it in a flip-flop that the shared clock pin loads. Each cell also returns one feedback bit to the array. That bit is the pin value, the flip-flop state, or a constant zero, depending on the cell's position and role.

A two-bit global mode sets the rules shared by all cells. Simple mode has no enable term, and the two centre cells are fixed as outputs. Complex mode takes product term 0 of every cell as its output enable, and the two outermost cells lose their pin feedback. Registered mode lets each cell be a clocked output, a combinatorial I/O or a dedicated input. Per-cell bits select registered, input and inverted operation. Each pin is brought out as a data/enable pair, and a disabled pin drives 0 on its data line.

Top module: `pld_mc_array`

## Requirements
- R1: In a cell, term 0 is the enable term and terms 1 to 7 form the 7-term sum. The 8-term sum includes term 0. Term k of cell c is bit c*8+k of `pterm`.
- R2: When `cfg_pol[c]` is 1, the sum of cell c is inverted before it is stored or driven.
- R3: In registered mode, a registered cell behaves as follows. On each rising `clk` its flip-flop loads (8-term sum XOR polarity). The pin drives the inverted flip-flop value. The pin is enabled while `oe_pin_n` is 0. The feedback bit is the flip-flop value.
- R4: In registered mode, a cell with `cfg_reg[c]`=0 and `cfg_input[c]`=0 behaves as follows. Its pin enable is term 0. Its data is the 7-term sum XOR polarity. Its feedback is `pin_in[c]`.
- R5: In registered mode, or in simple mode for any cell except 3 and 4, `cfg_input[c]`=1 turns the cell into an input. Its pin stays disabled and its feedback is `pin_in[c]`. In registered mode this setting overrides `cfg_reg[c]`.
- R6: In complex mode, every cell enables its pin with term 0 and drives the 7-term sum XOR polarity. Cells 1 to 6 feed back `pin_in`. Cells 0 and 7 feed back 0. `cfg_reg` and `cfg_input` have no effect.
- R7: In simple mode, every output cell is always enabled and drives the 8-term sum XOR polarity. Cells 3 and 4 are always outputs and feed back 0. The other output cells feed back `pin_in`.
- R8: While `rst` is 1 at a rising `clk`, every flip-flop is cleared and does not load the sum. After reset, an enabled registered pin reads 1.
- R9: A pin whose enable is 0 drives 0 on `pin_out`.
- R10: The mode is encoded as 00 for simple, 01 for complex and 10 for registered. The value 11 behaves exactly like simple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin for the macrocell flip-flops |
| rst | input | 1 | Synchronous active-high power-up reset |
| oe_pin_n | input | 1 | Shared active-low output enable for registered cells |
| mode | input | 2 | Global mode: 00 simple, 01 complex, 10 registered, 11 as simple |
| cfg_reg | input | 8 | Per-cell registered select (registered mode) |
| cfg_input | input | 8 | Per-cell dedicated-input select |
| cfg_pol | input | 8 | Per-cell sum inversion |
| pterm | input | 64 | Product terms, 8 per cell, cell c at bits c*8+7..c*8 |
| pin_in | input | 8 | Resolved value seen on each I/O pin |
| pin_out | output | 8 | Pin drive data, 0 when disabled |
| pin_oe | output | 8 | Pin drive enable |
| fb | output | 8 | Feedback bits to the AND-array |

## Verification
The bench targets several corner cases. A cell with only term 0 set must enable its pin yet drive 0 in complex mode, and drive 1 in simple mode. A design that mixed up the 7-term and 8-term sums shows the wrong data bit. A clock edge during reset with all terms high must leave every registered pin reading 1; a flip-flop that loaded during reset would read 0 instead. The bench sets every input and registered select bit in each mode. A design that failed to fix the centre cells as outputs, honoured `cfg_input` in complex mode, or let a registered select override an input select would enable the wrong pins. The reserved mode value is also applied. A decoder that treated it as registered or complex would show enables taken from the shared pin or from term 0.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'b00,
    MODE_COMPLEX = 2'b01,
    MODE_REGD    = 2'b10,
    MODE_RSVD    = 2'b11
  } pld_mode_e;
endpackage

// File: rtl/pld_sum.sv
module pld_sum #(
  parameter int NPT = 8
) (
  input  logic [NPT-1:0] pt,
  output logic           sum_all,
  output logic           sum_tail
);
  // term 0 doubles as the enable term; the tail sum leaves it out
  always_comb begin
    sum_tail = 1'b0;
    for (int k = 1; k < NPT; k++) sum_tail = sum_tail | pt[k];
    sum_all = sum_tail | pt[0];
  end
endmodule

// File: rtl/pld_cell.sv
module pld_cell
  import pld_mc_pkg::*;
#(
  parameter int NPT    = 8,
  parameter bit OUTER  = 1'b0,
  parameter bit CENTRE = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  pld_mode_e      mode,
  input  logic           reg_sel,
  input  logic           in_sel,
  input  logic           pol,
  input  logic           glb_oe,
  input  logic [NPT-1:0] pt,
  input  logic           pin_in,
  output logic           pin_out,
  output logic           pin_oe,
  output logic           fb
);
  logic sum_all, sum_tail, q, drv;

  pld_sum #(.NPT(NPT)) u_sum (
    .pt      (pt),
    .sum_all (sum_all),
    .sum_tail(sum_tail)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= sum_all ^ pol;
  end

  always_comb begin
    pin_oe = 1'b0;
    drv    = 1'b0;
    fb     = pin_in;
    case (mode)
      MODE_REGD: begin
        if (in_sel) begin
          pin_oe = 1'b0;
        end else if (reg_sel) begin
          pin_oe = glb_oe;
          drv    = ~q;
          fb     = q;
        end else begin
          pin_oe = pt[0];
          drv    = sum_tail ^ pol;
        end
      end
      MODE_COMPLEX: begin
        pin_oe = pt[0];
        drv    = sum_tail ^ pol;
        if (OUTER) fb = 1'b0;
      end
      default: begin
        if (CENTRE) begin
          pin_oe = 1'b1;
          drv    = sum_all ^ pol;
          fb     = 1'b0;
        end else if (!in_sel) begin
          pin_oe = 1'b1;
          drv    = sum_all ^ pol;
        end
      end
    endcase
    pin_out = pin_oe & drv;
  end

  // R8: first cycle after reset an enabled registered pin reads high
  p_release_high_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && mode == MODE_REGD && reg_sel && !in_sel && glb_oe) |-> pin_out);

  // R3: registered pin shows the inverted sum captured one edge earlier
  p_reg_track_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode == MODE_REGD && reg_sel && !in_sel && glb_oe)
      |-> (pin_out == !($past(sum_all) ^ $past(pol))));

  // R5: an input cell in registered mode never drives
  p_input_off_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REGD && in_sel) |-> !pin_oe);

  // R9: nothing on the data line of a disabled pin
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);

  generate
    if (OUTER) begin : g_outer
      // R6: outermost cells have no feedback in complex mode
      p_outer_nofb_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMPLEX) |-> !fb);
    end
    if (CENTRE) begin : g_centre
      // R7: centre cells stay driven outputs in simple mode
      p_centre_on_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SIMPLE || mode == MODE_RSVD) |-> (pin_oe && !fb));
    end
  endgenerate
endmodule

// File: rtl/pld_mc_array.sv
module pld_mc_array
  import pld_mc_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int N_PT    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    oe_pin_n,
  input  logic [1:0]              mode,
  input  logic [N_CELLS-1:0]      cfg_reg,
  input  logic [N_CELLS-1:0]      cfg_input,
  input  logic [N_CELLS-1:0]      cfg_pol,
  input  logic [N_CELLS*N_PT-1:0] pterm,
  input  logic [N_CELLS-1:0]      pin_in,
  output logic [N_CELLS-1:0]      pin_out,
  output logic [N_CELLS-1:0]      pin_oe,
  output logic [N_CELLS-1:0]      fb
);
  localparam int CENTRE_LO = N_CELLS / 2 - 1;
  localparam int CENTRE_HI = N_CELLS / 2;

  pld_mode_e mode_e;
  logic      glb_oe;

  assign mode_e = pld_mode_e'(mode);
  assign glb_oe = ~oe_pin_n;

  generate
    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
      pld_cell #(
        .NPT   (N_PT),
        .OUTER (g == 0 || g == N_CELLS - 1),
        .CENTRE(g == CENTRE_LO || g == CENTRE_HI)
      ) u_cell (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_e),
        .reg_sel(cfg_reg[g]),
        .in_sel (cfg_input[g]),
        .pol    (cfg_pol[g]),
        .glb_oe (glb_oe),
        .pt     (pterm[g*N_PT +: N_PT]),
        .pin_in (pin_in[g]),
        .pin_out(pin_out[g]),
        .pin_oe (pin_oe[g]),
        .fb     (fb[g])
      );
    end
  endgenerate

  // R3: shared enable pin gates every registered, non-input cell
  p_shared_oe_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> ((pin_oe & cfg_reg & ~cfg_input) == ({N_CELLS{!oe_pin_n}} & cfg_reg & ~cfg_input)));
endmodule

// File: tb/pld_mc_array_test.sv
module pld_mc_array_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oe_pin_n = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  cfg_reg = '0, cfg_input = '0, cfg_pol = '0, pin_in = '0;
  logic [63:0] pterm = '0;
  logic [7:0]  pin_out, pin_oe, fb;

  int   vectors = 0;
  int   miscompares = 0;
  logic [7:0] mq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_mc_array uut (
    .clk(clk), .rst(rst), .oe_pin_n(oe_pin_n), .mode(mode),
    .cfg_reg(cfg_reg), .cfg_input(cfg_input), .cfg_pol(cfg_pol),
    .pterm(pterm), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  function automatic void model(input logic [1:0] m, input logic [7:0] rs, is, pl,
                                input logic [63:0] p, input logic oen,
                                input logic [7:0] q, pins,
                                output logic [7:0] eo, ed, ef);
    for (int c = 0; c < 8; c++) begin
      logic [7:0] t;
      logic s8, s7, o, d, f, outer, centre;
      t = p[c*8 +: 8];
      s8 = |t;
      s7 = |t[7:1];
      outer  = (c == 0 || c == 7);
      centre = (c == 3 || c == 4);
      o = 1'b0; d = 1'b0; f = pins[c];
      if (m == 2'b10) begin
        if (is[c]) o = 1'b0;
        else if (rs[c]) begin o = !oen; d = !q[c]; f = q[c]; end
        else begin o = t[0]; d = s7 ^ pl[c]; end
      end else if (m == 2'b01) begin
        o = t[0]; d = s7 ^ pl[c];
        if (outer) f = 1'b0;
      end else begin
        if (centre) begin o = 1'b1; d = s8 ^ pl[c]; f = 1'b0; end
        else if (!is[c]) begin o = 1'b1; d = s8 ^ pl[c]; end
      end
      eo[c] = o;
      ed[c] = o & d;
      ef[c] = f;
    end
  endfunction

  task automatic apply(input string tag, input logic r, input logic oen, input logic [1:0] m,
                       input logic [7:0] rs, is, pl, input logic [63:0] p);
    logic [7:0] eo, ed, ef, pins;
    string t;
    @(negedge clk);
    rst = r; oe_pin_n = oen; mode = m; cfg_reg = rs; cfg_input = is; cfg_pol = pl; pterm = p;
    pins = 8'($urandom);
    model(m, rs, is, pl, p, oen, mq, pins, eo, ed, ef);
    pins = (pins & ~eo) | (ed & eo);
    pin_in = pins;
    model(m, rs, is, pl, p, oen, mq, pins, eo, ed, ef);
    #2;
    t = tag;
    if (t == "") t = (m == 2'b10) ? "R3 R4 R5" : (m == 2'b01) ? "R6" : (m == 2'b00) ? "R7" : "R10";
    vectors++;
    if (pin_oe !== eo || pin_out !== ed || fb !== ef) begin
      miscompares++;
      $display("FAIL %s: oe=%b out=%b fb=%b expected oe=%b out=%b fb=%b",
               t, pin_oe, pin_out, fb, eo, ed, ef);
    end
    @(posedge clk);
    if (r) mq = '0;
    else for (int c = 0; c < 8; c++) mq[c] = (|p[c*8 +: 8]) ^ pl[c];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (2) @(posedge clk);
    // R8: edge during reset with every term high must not load
    apply("R8", 1'b1, 1'b0, 2'b10, 8'hFF, 8'h00, 8'h00, {64{1'b1}});
    apply("R8", 1'b0, 1'b0, 2'b10, 8'hFF, 8'h00, 8'h00, {64{1'b1}});
    // R3: flip-flop now holds 1, pin drives 0; then shared enable off
    apply("R3", 1'b0, 1'b0, 2'b10, 8'hFF, 8'h00, 8'h00, 64'h0);
    apply("R3", 1'b0, 1'b1, 2'b10, 8'hFF, 8'h00, 8'h55, {8{8'h10}});
    apply("R3", 1'b0, 1'b0, 2'b10, 8'hFF, 8'h00, 8'h00, 64'h0);
    // R1: term 0 alone enables but is not in the 7-term sum
    apply("R1", 1'b0, 1'b0, 2'b01, 8'h00, 8'h00, 8'h00, {8{8'h01}});
    apply("R1", 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 8'h00, {8{8'h01}});
    apply("R1", 1'b0, 1'b0, 2'b01, 8'h00, 8'h00, 8'h00, {8{8'h81}});
    // R2: alternating inversion
    apply("R2", 1'b0, 1'b0, 2'b01, 8'h00, 8'h00, 8'hAA, {8{8'h03}});
    apply("R2", 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 8'h5A, {{4{8'h00}}, {4{8'h40}}});
    // R4: combinatorial cells in registered mode
    apply("R4", 1'b0, 1'b0, 2'b10, 8'h00, 8'h00, 8'h0F, {{4{8'h21}}, {4{8'h01}}});
    // R9: disabled combinatorial cell with a true sum drives 0
    apply("R9", 1'b0, 1'b0, 2'b10, 8'h00, 8'h00, 8'h00, {8{8'hFE}});
    // R5: input select wins over registered select
    apply("R5", 1'b0, 1'b0, 2'b10, 8'hFF, 8'hFF, 8'h00, {64{1'b1}});
    apply("R5", 1'b0, 1'b0, 2'b00, 8'h00, 8'hFF, 8'h00, {64{1'b1}});
    // R6: select bits ignored in complex mode
    apply("R6", 1'b0, 1'b0, 2'b01, 8'hFF, 8'hFF, 8'h00, {8{8'h05}});
    // R7: centre cells stay outputs
    apply("R7", 1'b0, 1'b0, 2'b00, 8'h00, 8'hFF, 8'hFF, 64'h0);
    // R10: reserved code acts as simple
    apply("R10", 1'b0, 1'b0, 2'b11, 8'hFF, 8'h99, 8'h00, {8{8'h01}});
    for (int i = 0; i < 800; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      apply("", ($urandom % 25) == 0, 1'($urandom), 2'($urandom),
            8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom), p);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule